// File: doc/BRIEF.md
# Periodic Comparator Timer Channel

This block is one comparator channel of an event timer. A shared main counter of `CNT_W` bits is driven from outside, together with a tick strobe and a global enable. The channel holds a compare value. When the counter equals that value on a tick while the global enable is high, the channel raises a single-cycle fire pulse toward the interrupt router.

The channel has two modes. In one-shot mode, a comparator write places the new compare point directly. In periodic mode, the channel also keeps a period. After each periodic fire, it moves the compare point forward onto the next point of the period lattice that lies strictly ahead of the counter. This forward move adds the period once per cycle until the result passes the counter, and matching is held off while the move is in progress. A value-set bit in the configuration decides whether a periodic comparator write also moves the live compare point, or only the period.

The register interface supplies write strobes with data and byte enables. It reads back the configuration image and the live compare value. Bus decode and interrupt routing sit outside the block.

Top module: `cmp_tick_channel`

## Requirements
- R1: While and after reset with no writes, the compare readback is 0xFFFFFFFF and the configuration readback is 0x8010.
- R2: Only configuration bit 3 (periodic mode) and bit 6 (value-set) are writable. Bits 4 and 15 always read 1, bit 8 always reads 0, and all other bits read 0, so writing 0xFFFF reads back 0x8058.
- R3: Leaving periodic mode zeroes the period. A later periodic fire with no new comparator write then leaves the compare value unchanged.
- R4: In one-shot mode, a comparator write merges the written bytes, selected by the byte enables, into the compare value. Without a write or a reload, the compare value holds.
- R5: In periodic mode, a comparator write always loads the period. The compare value takes the written value only when the value-set bit is 1. The value-set bit reads 0 after any comparator write, in either mode.
- R6: `fire_o` is high for exactly the one cycle after a clock edge at which `tick_i`, `gen_en_i` and counter==compare all hold. There is no fire without a tick (except the R11 case), and no fire while the global enable stays low.
- R7: A one-shot compare point that the counter has already passed does not fire until the counter comes around to it again after wrapping.
- R8: After a periodic fire with a nonzero period, the compare value becomes compare + (floor((counter−compare)/period)+1)·period, modulo 2^CNT_W. No fire occurs while this reload is in progress.
- R9: When the global enable rises in periodic mode with a nonzero period, and the compare point lies behind the held counter by less than half the counter range, the compare value is advanced by the R8 formula using the held counter.
- R10: When the global enable falls while the counter equals the compare value, a single fire pulse is produced even without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | CNT_W | Shared main counter value |
| tick_i | input | 1 | Counter advance strobe |
| gen_en_i | input | 1 | Global counter enable |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | CFG_W | Configuration write data |
| cfg_be_i | input | CFG_W/8 | Configuration byte enables |
| cmp_we_i | input | 1 | Comparator write strobe |
| cmp_wdata_i | input | CNT_W | Comparator write data |
| cmp_be_i | input | CNT_W/8 | Comparator byte enables |
| fire_o | output | 1 | One-cycle fire event |
| cfg_rd_o | output | CFG_W | Configuration readback image |
| cmp_rd_o | output | CNT_W | Live compare value readback |

## Verification
A reload that computes the wrong lattice point appears on the compare readback a few cycles after the fire, once the per-cycle additions finish. It then appears as a missing or misplaced fire on the next periodic tick. A stale period or value-set bit cannot be seen until the next comparator write or periodic fire: it then shows as a compare readback that moved, or failed to move. A broken enable edge detector shows within one cycle of the enable toggling, either as a spurious or missing fire pulse, or as a compare value that was not snapped forward on rearm.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

    localparam int CNT_W = 32;
    localparam int CFG_W = 16;

    localparam int BIT_PERIODIC = 3;
    localparam int BIT_PER_CAP  = 4;
    localparam int BIT_VALSET   = 6;
    localparam int BIT_W32      = 8;
    localparam int BIT_MSG_CAP  = 15;

    typedef struct packed {
        logic periodic;
        logic valset;
    } cfg_t;

    function automatic logic [CFG_W-1:0] cfg_image(input cfg_t c);
        logic [CFG_W-1:0] img;
        img               = '0;
        img[BIT_PER_CAP]  = 1'b1;
        img[BIT_MSG_CAP]  = 1'b1;
        img[BIT_W32]      = 1'b0;
        img[BIT_PERIODIC] = c.periodic;
        img[BIT_VALSET]   = c.valset;
        return img;
    endfunction

endpackage

// File: rtl/ctc_cfg_reg.sv
module ctc_cfg_reg
    import ctc_pkg::*;
#(
    parameter int CW = CFG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [CW-1:0]     wdata_i,
    input  logic [CW/8-1:0]   be_i,
    input  logic              cmp_we_i,
    output cfg_t              cfg_o,
    output logic [CW-1:0]     rd_o
);
    localparam int PER_BYTE = BIT_PERIODIC / 8;
    localparam int VS_BYTE  = BIT_VALSET / 8;

    cfg_t cfg_q, cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            if (be_i[PER_BYTE]) cfg_d.periodic = wdata_i[BIT_PERIODIC];
            if (be_i[VS_BYTE])  cfg_d.valset   = wdata_i[BIT_VALSET];
        end
        if (cmp_we_i) cfg_d.valset = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;
    assign rd_o  = cfg_image(cfg_q);

    AST_VALSET_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        cmp_we_i |=> !rd_o[BIT_VALSET]); // R5

endmodule

// File: rtl/ctc_cmp_regs.sv
module ctc_cmp_regs
    import ctc_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  cfg_t             cfg_i,
    input  logic             we_i,
    input  logic [W-1:0]     wdata_i,
    input  logic [W/8-1:0]   be_i,
    input  logic             rl_done_i,
    input  logic [W-1:0]     rl_value_i,
    output logic [W-1:0]     cmp_o,
    output logic [W-1:0]     per_o
);
    localparam int NB = W / 8;

    logic [W-1:0] cmp_q, per_q, bmask, cmp_m, per_m;

    for (genvar b = 0; b < NB; b++) begin : g_mask
        assign bmask[b*8 +: 8] = {8{be_i[b]}};
    end

    assign cmp_m = (cmp_q & ~bmask) | (wdata_i & bmask);
    assign per_m = (per_q & ~bmask) | (wdata_i & bmask);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '1;
            per_q <= '0;
        end else begin
            if (!cfg_i.periodic) per_q <= '0;
            if (we_i) begin
                if (cfg_i.periodic) begin
                    per_q <= per_m;
                    if (cfg_i.valset) cmp_q <= per_m;
                end else begin
                    cmp_q <= cmp_m;
                end
            end else if (rl_done_i) begin
                cmp_q <= rl_value_i;
            end
        end
    end

    assign cmp_o = cmp_q;
    assign per_o = per_q;

    AST_PERIOD_ZERO_ONESHOT: assert property (@(posedge clk) disable iff (rst)
        !cfg_i.periodic |=> per_q == '0); // R3

    AST_CMP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!we_i && !rl_done_i) |=> $stable(cmp_q)); // R4

endmodule

// File: rtl/ctc_reload.sv
module ctc_reload
    import ctc_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          abort_i,
    input  logic [W-1:0]  base_i,
    input  logic [W-1:0]  cnt_i,
    input  logic [W-1:0]  per_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [W-1:0]  value_o
);
    logic          busy_q;
    logic [W:0]    acc_q;
    logic [W-1:0]  dist_q, base_q, snap_q, per_q;
    logic [W-1:0]  ahead;

    assign done_o  = busy_q && (acc_q > {1'b0, dist_q});
    assign value_o = base_q + acc_q[W-1:0];
    assign busy_o  = busy_q;
    assign ahead   = value_o - snap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            acc_q  <= '0;
            dist_q <= '0;
            base_q <= '0;
            snap_q <= '0;
            per_q  <= '0;
        end else if (abort_i) begin
            busy_q <= 1'b0;
        end else if (start_i) begin
            busy_q <= 1'b1;
            acc_q  <= {1'b0, per_i};
            dist_q <= cnt_i - base_i;
            base_q <= base_i;
            snap_q <= cnt_i;
            per_q  <= per_i;
        end else if (busy_q) begin
            if (done_o) busy_q <= 1'b0;
            else        acc_q  <= acc_q + {1'b0, per_q};
        end
    end

    AST_RELOAD_AHEAD: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (ahead != '0 && ahead <= per_q)); // R8

endmodule

// File: rtl/ctc_match.sv
module ctc_match
    import ctc_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  cnt_i,
    input  logic [W-1:0]  cmp_i,
    input  logic          tick_i,
    input  logic          en_i,
    input  logic          hold_i,
    output logic          hit_o,
    output logic          en_rise_o,
    output logic          fire_o
);
    logic en_q, fire_q, eq, stop;

    assign eq        = (cnt_i == cmp_i);
    assign hit_o     = tick_i && en_i && eq && !hold_i;
    assign stop      = en_q && !en_i && eq && !hold_i;
    assign en_rise_o = en_i && !en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            fire_q <= 1'b0;
        end else begin
            en_q   <= en_i;
            fire_q <= hit_o || stop;
        end
    end

    assign fire_o = fire_q;

    AST_FIRE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        fire_q |-> $past((tick_i && en_i) || (en_q && !en_i))); // R6

    AST_NO_FIRE_DURING_RELOAD: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> !fire_q); // R8

endmodule

// File: rtl/cmp_tick_channel.sv
module cmp_tick_channel
    import ctc_pkg::*;
#(
    parameter int CNT_W = ctc_pkg::CNT_W,
    parameter int CFG_W = ctc_pkg::CFG_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CNT_W-1:0]   cnt_i,
    input  logic               tick_i,
    input  logic               gen_en_i,
    input  logic               cfg_we_i,
    input  logic [CFG_W-1:0]   cfg_wdata_i,
    input  logic [CFG_W/8-1:0] cfg_be_i,
    input  logic               cmp_we_i,
    input  logic [CNT_W-1:0]   cmp_wdata_i,
    input  logic [CNT_W/8-1:0] cmp_be_i,
    output logic               fire_o,
    output logic [CFG_W-1:0]   cfg_rd_o,
    output logic [CNT_W-1:0]   cmp_rd_o
);
    cfg_t             cfg;
    logic [CNT_W-1:0] cmp_val, per_val, rl_value, lag;
    logic             rl_busy, rl_done, rl_start, hit, en_rise, per_live;

    ctc_cfg_reg #(.CW(CFG_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .we_i     (cfg_we_i),
        .wdata_i  (cfg_wdata_i),
        .be_i     (cfg_be_i),
        .cmp_we_i (cmp_we_i),
        .cfg_o    (cfg),
        .rd_o     (cfg_rd_o)
    );

    ctc_cmp_regs #(.W(CNT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_i      (cfg),
        .we_i       (cmp_we_i),
        .wdata_i    (cmp_wdata_i),
        .be_i       (cmp_be_i),
        .rl_done_i  (rl_done),
        .rl_value_i (rl_value),
        .cmp_o      (cmp_val),
        .per_o      (per_val)
    );

    ctc_match #(.W(CNT_W)) u_match (
        .clk       (clk),
        .rst       (rst),
        .cnt_i     (cnt_i),
        .cmp_i     (cmp_val),
        .tick_i    (tick_i),
        .en_i      (gen_en_i),
        .hold_i    (rl_busy),
        .hit_o     (hit),
        .en_rise_o (en_rise),
        .fire_o    (fire_o)
    );

    assign per_live = cfg.periodic && (per_val != '0);
    assign lag      = cnt_i - cmp_val;
    assign rl_start = per_live && (hit || (en_rise && !lag[CNT_W-1]));

    ctc_reload #(.W(CNT_W)) u_reload (
        .clk     (clk),
        .rst     (rst),
        .start_i (rl_start),
        .abort_i (cmp_we_i),
        .base_i  (cmp_val),
        .cnt_i   (cnt_i),
        .per_i   (per_val),
        .busy_o  (rl_busy),
        .done_o  (rl_done),
        .value_o (rl_value)
    );

    assign cmp_rd_o = cmp_val;

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (cmp_rd_o == '1 && cfg_rd_o[BIT_PERIODIC] == 1'b0)); // R1

    AST_ONESHOT_NO_RELOAD: assert property (@(posedge clk) disable iff (rst)
        !cfg.periodic |=> !rl_start); // R3

endmodule

// File: tb/cmp_tick_channel_tb_top.sv
module cmp_tick_channel_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] cnt;
    logic        tick, en;
    logic        cfg_we;
    logic [15:0] cfg_wdata;
    logic [1:0]  cfg_be;
    logic        cmp_we;
    logic [31:0] cmp_wdata;
    logic [3:0]  cmp_be;
    logic        fire;
    logic [15:0] cfg_rd;
    logic [31:0] cmp_rd;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    cmp_tick_channel dut_i (
        .clk(clk), .rst(rst), .cnt_i(cnt), .tick_i(tick), .gen_en_i(en),
        .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_be_i(cfg_be),
        .cmp_we_i(cmp_we), .cmp_wdata_i(cmp_wdata), .cmp_be_i(cmp_be),
        .fire_o(fire), .cfg_rd_o(cfg_rd), .cmp_rd_o(cmp_rd)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = d; cfg_be = 2'b11;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_cmp(input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        cmp_we = 1'b1; cmp_wdata = d; cmp_be = be;
        @(negedge clk);
        cmp_we = 1'b0;
    endtask

    // one tick at counter value v; returns the fire output one cycle later
    task automatic do_tick(input logic [31:0] v, output logic fired);
        @(negedge clk);
        cnt = v; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        fired = fire;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        idle(3);
        chk("R1 cmp in reset", cmp_rd, 32'hFFFF_FFFF);
        chk("R1 cfg in reset", {16'h0, cfg_rd}, 32'h0000_8010);
        rst = 1'b0;
        idle(2);
        chk("R1 cmp after reset", cmp_rd, 32'hFFFF_FFFF);
        chk("R1 cfg after reset", {16'h0, cfg_rd}, 32'h0000_8010);
    endtask

    task automatic t_cfg_bits();
        wr_cfg(16'hFFFF);
        chk("R2 cfg all ones", {16'h0, cfg_rd}, 32'h0000_8058);
        wr_cfg(16'h0000);
        chk("R2 cfg zero", {16'h0, cfg_rd}, 32'h0000_8010);
    endtask

    task automatic t_oneshot_write();
        wr_cmp(32'h1234_5678, 4'b1111);
        chk("R4 full write", cmp_rd, 32'h1234_5678);
        wr_cmp(32'hAABB_CCDD, 4'b0100);
        chk("R4 byte write", cmp_rd, 32'h12BB_5678);
        wr_cfg(16'h0040);
        chk("R5 valset set", {31'h0, cfg_rd[6]}, 32'h1);
        wr_cmp(32'h0000_0100, 4'b1111);
        chk("R5 valset clear one-shot", {31'h0, cfg_rd[6]}, 32'h0);
        chk("R4 one-shot load", cmp_rd, 32'h0000_0100);
    endtask

    task automatic t_match();
        logic f;
        en = 1'b1;
        do_tick(32'h0FF, f);
        chk("R6 no match", {31'h0, f}, 32'h0);
        do_tick(32'h100, f);
        chk("R6 match fires", {31'h0, f}, 32'h1);
        @(negedge clk);
        chk("R6 one cycle", {31'h0, fire}, 32'h0);
        cnt = 32'h0;
        en = 1'b0;
        idle(2);
        do_tick(32'h100, f);
        chk("R6 no fire disabled", {31'h0, f}, 32'h0);
    endtask

    task automatic t_passed();
        logic f;
        cnt = 32'h60;
        en = 1'b1;
        wr_cmp(32'h50, 4'b1111);
        do_tick(32'h61, f);
        chk("R7 passed no fire a", {31'h0, f}, 32'h0);
        do_tick(32'hFFFF_FFFF, f);
        chk("R7 passed no fire b", {31'h0, f}, 32'h0);
        do_tick(32'h0, f);
        chk("R7 passed no fire c", {31'h0, f}, 32'h0);
        do_tick(32'h50, f);
        chk("R7 fires after wrap", {31'h0, f}, 32'h1);
    endtask

    task automatic t_periodic();
        logic f;
        wr_cfg(16'h0048);
        wr_cmp(32'h200, 4'b1111);
        chk("R5 valset moves cmp", cmp_rd, 32'h200);
        chk("R5 valset cleared periodic", {31'h0, cfg_rd[6]}, 32'h0);
        wr_cmp(32'h10, 4'b1111);
        chk("R5 no valset keeps cmp", cmp_rd, 32'h200);
        do_tick(32'h200, f);
        chk("R8 periodic fire", {31'h0, f}, 32'h1);
        idle(3);
        chk("R8 reload one period", cmp_rd, 32'h210);
        do_tick(32'h205, f);
        chk("R8 no early fire", {31'h0, f}, 32'h0);
        do_tick(32'h210, f);
        chk("R8 second fire", {31'h0, f}, 32'h1);
        idle(3);
        chk("R8 second reload", cmp_rd, 32'h220);
    endtask

    task automatic t_rearm();
        @(negedge clk);
        cnt = 32'h211;
        en = 1'b0;
        idle(2);
        cnt = 32'h245;
        idle(1);
        en = 1'b1;
        idle(8);
        chk("R9 rearm snaps forward", cmp_rd, 32'h250);
        chk("R9 no fire on rearm", {31'h0, fire}, 32'h0);
        en = 1'b0;
        cnt = 32'h240;
        idle(2);
        en = 1'b1;
        idle(8);
        chk("R9 ahead point kept", cmp_rd, 32'h250);
    endtask

    task automatic t_stop_fire();
        @(negedge clk);
        cnt = 32'h250; tick = 1'b0;
        @(negedge clk);
        chk("R6 no fire without tick", {31'h0, fire}, 32'h0);
        en = 1'b0;
        @(negedge clk);
        chk("R10 stop fire", {31'h0, fire}, 32'h1);
        @(negedge clk);
        chk("R10 single pulse", {31'h0, fire}, 32'h0);
    endtask

    task automatic t_period_clear();
        logic f;
        wr_cfg(16'h0000);
        wr_cfg(16'h0008);
        chk("R3 cfg periodic", {16'h0, cfg_rd}, 32'h0000_8018);
        cnt = 32'h0;
        en = 1'b1;
        idle(2);
        do_tick(32'h250, f);
        chk("R3 fire", {31'h0, f}, 32'h1);
        idle(4);
        chk("R3 zero period no reload", cmp_rd, 32'h250);
    endtask

    initial begin
        rst = 1'b1; cnt = '0; tick = 1'b0; en = 1'b0;
        cfg_we = 1'b0; cfg_wdata = '0; cfg_be = '0;
        cmp_we = 1'b0; cmp_wdata = '0; cmp_be = '0;
        t_reset();
        t_cfg_bits();
        t_oneshot_write();
        t_match();
        t_passed();
        t_periodic();
        t_rearm();
        t_stop_fire();
        t_period_clear();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule